// File: doc/BRIEF.md
# Transport Stream Packet Output Formatter

This block sits at the end of a broadcast receive chain. It pulls decoded 188-byte transport packets out of an internal byte buffer through a ready/valid handshake and drives them onto an output port. Each packet comes with an uncorrectable flag. The port is either 8 bits wide, one byte per output clock, or serial, one bit per output clock. Three strobes go with the data: one marks the packet start, one marks valid data, and an active-low block-error strobe marks packets that could not be corrected.

When enabled, the formatter rewrites the header of every uncorrectable packet so that downstream demultiplexers see the transport error indicator set. The output launch edge can be chosen so that the receiver samples on either clock edge. In serial mode, the data can be placed on the lowest or the highest bus line. The whole block runs on the output clock. Choosing that clock's rate and the pad timing are left to the surrounding logic.

The byte source must hold whole packets. Once the first byte of a packet has been accepted, it must present every further byte as soon as `src_ready` asks for it.

Top module: `ts_out_formatter`

## Requirements
- R1: A packet occupies 188 consecutive byte slots with no idle slot inside it. In parallel mode a slot is one output clock and byte k of the packet appears on `ts_data` in slot k.
- R2: Between packets, `ts_data` is all zeros, `ts_valid` and `ts_start` are low, and `ts_blk_err_n` is high.
- R3: `ts_start` is high only while the first byte (the 0x47 sync byte position) is on the port. That is one clock in parallel mode and eight clocks in serial mode.
- R4: `ts_valid` is high from the first slot of a packet through its last slot, inclusive.
- R5: For a packet accepted with `src_err`=1, `ts_blk_err_n` is low on every slot of that packet. For a packet accepted with `src_err`=0, it stays high.
- R6: With `cfg_tei_force`=1, bit 7 of byte index 1 (the byte after the sync byte) of an uncorrectable packet leaves as 1. With `cfg_tei_force`=0 that byte leaves unchanged. Bytes of correct packets are never altered.
- R7: With `cfg_edge_rise`=0, all outputs change on the falling clock edge, half a period after the rising edge at which the engine advanced. With `cfg_edge_rise`=1, they change on that rising edge.
- R8: While `cfg_oe_n`=1, the outputs hold the gap values of R2 and, between packets, `src_ready` is low, so no byte is accepted.
- R9: With `cfg_serial`=1, each byte is sent MSB first over 8 clocks. With `cfg_lane_swap`=0 the bit is on `ts_data[0]`, and with `cfg_lane_swap`=1 it is on `ts_data[7]`. All other lines are zero.
- R10: A packet starts only at a rising edge where `src_valid` and `src_ready` are both high at a packet boundary. Otherwise the port stays in the gap state. When the source is valid in the last slot of a packet, the next packet follows with no gap.
- R11: After reset the outputs hold the gap values and `src_ready` equals the inverse of `cfg_oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | 8 | Byte from the packet buffer |
| src_err | input | 1 | Uncorrectable flag, sampled with the first byte of a packet |
| src_valid | input | 1 | Source holds a byte |
| src_ready | output | 1 | Formatter takes the byte at this rising edge |
| cfg_serial | input | 1 | 1 selects one-bit serial output |
| cfg_lane_swap | input | 1 | Serial bit on line 7 instead of line 0 |
| cfg_tei_force | input | 1 | Force error indicator of bad packets (normally tied 1) |
| cfg_edge_rise | input | 1 | 1 launches outputs on the rising edge (normally tied 0) |
| cfg_oe_n | input | 1 | Active-low output enable |
| ts_data | output | 8 | Packet data or serial bit |
| ts_start | output | 1 | Packet start strobe |
| ts_valid | output | 1 | Data valid strobe |
| ts_blk_err_n | output | 1 | Active-low block-error strobe |

## Verification
A byte accepted at rising edge n shapes the output slot that begins at that edge. It is visible right after edge n with rising launch, and from the falling edge that follows with the default launch. The bench therefore compares every output once per clock at three quarters of the period, where both launch modes must agree with the model. It takes a second sample at one quarter of the period to tell them apart: that sample must equal the current slot with rising launch and the previous slot with falling launch. The expected slot list for a packet is built when its first byte is accepted, and it is consumed one entry per clock. Any gap or shift inside a packet therefore shows up on the very cycle it happens.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;
    parameter int unsigned TS_BYTE_W_DEF   = 8;
    parameter int unsigned TS_PKT_LEN_DEF  = 188;
    parameter int unsigned TS_TEI_BYTE_DEF = 1;
    parameter int unsigned TS_TEI_BIT_DEF  = 7;

    typedef enum logic {
        PH_GAP  = 1'b0,
        PH_SEND = 1'b1
    } fmt_phase_e;

    typedef enum logic {
        LAUNCH_FALL = 1'b0,
        LAUNCH_RISE = 1'b1
    } launch_edge_e;
endpackage

// File: rtl/ts_fmt_engine.sv
module ts_fmt_engine
    import ts_fmt_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned PKT_LEN  = 188,
    parameter int unsigned TEI_BYTE = 1,
    parameter int unsigned TEI_BIT  = 7,
    localparam int unsigned IDX_W   = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_serial,
    input  logic             cfg_tei_force,
    input  logic [W-1:0]     src_data,
    input  logic             src_err,
    input  logic             src_valid,
    output logic             src_ready,
    output logic             nxt_send,
    output logic             nxt_bad,
    output logic [IDX_W-1:0] nxt_idx,
    output logic [W-1:0]     nxt_shreg
);
    localparam int unsigned BIT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_LEN - 1);
    localparam logic [IDX_W-1:0] TEI_IDX  = IDX_W'(TEI_BYTE);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(W - 1);

    typedef struct packed {
        fmt_phase_e       phase;
        logic             bad;
        logic [IDX_W-1:0] idx;
        logic [BIT_W-1:0] bitc;
        logic [W-1:0]     shreg;
    } eng_st_t;

    eng_st_t          st_q, st_d;
    logic             slot_end;
    logic             at_bound;
    logic [IDX_W-1:0] idx_inc;
    logic [W-1:0]     fixed_byte;

    always_comb begin
        slot_end   = !cfg_serial || (st_q.bitc == BIT_LAST);
        at_bound   = (st_q.phase == PH_GAP) || (slot_end && (st_q.idx == IDX_LAST));
        src_ready  = at_bound ? en : slot_end;
        idx_inc    = st_q.idx + 1'b1;
        fixed_byte = src_data;
        if ((idx_inc == TEI_IDX) && st_q.bad && cfg_tei_force) begin
            fixed_byte[TEI_BIT] = 1'b1;
        end

        st_d = st_q;
        if (at_bound) begin
            if (en && src_valid) begin
                st_d = '{phase: PH_SEND, bad: src_err, idx: '0, bitc: '0, shreg: src_data};
            end else begin
                st_d = '{phase: PH_GAP, bad: 1'b0, idx: '0, bitc: '0, shreg: '0};
            end
        end else if (slot_end) begin
            st_d.idx   = idx_inc;
            st_d.bitc  = '0;
            st_d.shreg = fixed_byte;
        end else begin
            st_d.bitc  = st_q.bitc + 1'b1;
            st_d.shreg = st_q.shreg << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_GAP, bad: 1'b0, idx: '0, bitc: '0, shreg: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_send  = (st_d.phase == PH_SEND);
    assign nxt_bad   = st_d.bad;
    assign nxt_idx   = st_d.idx;
    assign nxt_shreg = st_d.shreg;

    // R1: the byte index never leaves the packet
    assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SEND) |-> (st_q.idx <= IDX_LAST));

    // R1: inside a packet each completed slot steps exactly one byte on
    assert_byte_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_SEND) && slot_end && !at_bound)
        |=> ((st_q.phase == PH_SEND) && (st_q.idx == $past(st_q.idx) + 1'b1)));

    // R10: no accepted first byte at a boundary means the gap state follows
    assert_no_partial_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bound && !(en && src_valid)) |=> (st_q.phase == PH_GAP));

    // R1: the source keeps a started packet gapless
    assert_source_gapless_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_SEND) && !at_bound && src_ready) |-> src_valid);
endmodule

// File: rtl/ts_fmt_lane_map.sv
module ts_fmt_lane_map #(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = 8
) (
    input  logic             en,
    input  logic             cfg_serial,
    input  logic             cfg_lane_swap,
    input  logic             send,
    input  logic             bad,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     shreg,
    output logic [W-1:0]     o_data,
    output logic             o_start,
    output logic             o_valid,
    output logic             o_err_n
);
    logic [W-1:0] ser_vec;

    for (genvar i = 0; i < W; i++) begin : g_lane
        if (W == 1) begin : g_single
            assign ser_vec[i] = shreg[W-1];
        end else if (i == 0) begin : g_low
            assign ser_vec[i] = !cfg_lane_swap && shreg[W-1];
        end else if (i == W - 1) begin : g_high
            assign ser_vec[i] = cfg_lane_swap && shreg[W-1];
        end else begin : g_quiet
            assign ser_vec[i] = 1'b0;
        end
    end

    always_comb begin
        if (en && send) begin
            o_data  = cfg_serial ? ser_vec : shreg;
            o_start = (idx == '0);
            o_valid = 1'b1;
            o_err_n = !bad;
        end else begin
            o_data  = '0;
            o_start = 1'b0;
            o_valid = 1'b0;
            o_err_n = 1'b1;
        end
    end
endmodule

// File: rtl/ts_fmt_launch.sv
module ts_fmt_launch
    import ts_fmt_pkg::*;
#(
    parameter int unsigned     VW       = 11,
    parameter logic [VW-1:0]   IDLE_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_rise,
    input  logic [VW-1:0] d,
    output logic [VW-1:0] q
);
    logic [VW-1:0] rise_q;
    logic [VW-1:0] fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= IDLE_VAL;
        else        rise_q <= d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= IDLE_VAL;
        else        fall_q <= rise_q;
    end

    always_comb begin
        q = (launch_edge_e'(edge_rise) == LAUNCH_RISE) ? rise_q : fall_q;
    end
endmodule

// File: rtl/ts_out_formatter.sv
module ts_out_formatter
    import ts_fmt_pkg::*;
#(
    parameter int unsigned DATA_W   = TS_BYTE_W_DEF,
    parameter int unsigned PKT_LEN  = TS_PKT_LEN_DEF,
    parameter int unsigned TEI_BYTE = TS_TEI_BYTE_DEF,
    parameter int unsigned TEI_BIT  = TS_TEI_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_err,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic              cfg_serial,
    input  logic              cfg_lane_swap,
    input  logic              cfg_tei_force,
    input  logic              cfg_edge_rise,
    input  logic              cfg_oe_n,
    output logic [DATA_W-1:0] ts_data,
    output logic              ts_start,
    output logic              ts_valid,
    output logic              ts_blk_err_n
);
    localparam int unsigned IDX_W = $clog2(PKT_LEN);
    localparam int unsigned VW    = DATA_W + 3;
    localparam logic [VW-1:0] IDLE_VEC = VW'(1);

    logic              out_en;
    logic              nxt_send, nxt_bad;
    logic [IDX_W-1:0]  nxt_idx;
    logic [DATA_W-1:0] nxt_shreg;
    logic [DATA_W-1:0] m_data;
    logic              m_start, m_valid, m_err_n;
    logic [VW-1:0]     pre_vec, out_vec;

    assign out_en = !cfg_oe_n;

    ts_fmt_engine #(
        .W(DATA_W), .PKT_LEN(PKT_LEN), .TEI_BYTE(TEI_BYTE), .TEI_BIT(TEI_BIT)
    ) i_engine (
        .clk(clk), .rst_n(rst_n), .en(out_en),
        .cfg_serial(cfg_serial), .cfg_tei_force(cfg_tei_force),
        .src_data(src_data), .src_err(src_err), .src_valid(src_valid),
        .src_ready(src_ready),
        .nxt_send(nxt_send), .nxt_bad(nxt_bad), .nxt_idx(nxt_idx), .nxt_shreg(nxt_shreg)
    );

    ts_fmt_lane_map #(.W(DATA_W), .IDX_W(IDX_W)) i_lane_map (
        .en(out_en), .cfg_serial(cfg_serial), .cfg_lane_swap(cfg_lane_swap),
        .send(nxt_send), .bad(nxt_bad), .idx(nxt_idx), .shreg(nxt_shreg),
        .o_data(m_data), .o_start(m_start), .o_valid(m_valid), .o_err_n(m_err_n)
    );

    assign pre_vec = {m_data, m_start, m_valid, m_err_n};

    ts_fmt_launch #(.VW(VW), .IDLE_VAL(IDLE_VEC)) i_launch (
        .clk(clk), .rst_n(rst_n), .edge_rise(cfg_edge_rise),
        .d(pre_vec), .q(out_vec)
    );

    assign ts_data      = out_vec[VW-1:3];
    assign ts_start     = out_vec[2];
    assign ts_valid     = out_vec[1];
    assign ts_blk_err_n = out_vec[0];

    // R2: the bus is quiet outside packets
    assert_gap_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |-> ((ts_data == '0) && !ts_start && ts_blk_err_n));

    // R3: the start strobe only appears inside a packet
    assert_start_in_pkt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ts_start |-> ts_valid);

    // R5: the error strobe only appears inside a packet
    assert_err_in_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_blk_err_n |-> ts_valid);

    // R5: the error strobe holds its level until the packet ends
    assert_err_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && $past(ts_valid) && !ts_start) |-> $stable(ts_blk_err_n));

    // R9: serial data uses a single line
    assert_serial_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_serial |-> ($countones(ts_data) <= 1));

    // R8: a disabled port is quiet
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_oe_n) && cfg_oe_n) |-> !ts_valid);
endmodule

// File: tb/test_ts_out_formatter.sv
module test_ts_out_formatter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_err = 1'b0;
    logic       src_valid = 1'b0;
    logic       src_ready;
    logic       cfg_serial = 1'b0, cfg_lane_swap = 1'b0, cfg_tei_force = 1'b1;
    logic       cfg_edge_rise = 1'b0, cfg_oe_n = 1'b0;
    logic [7:0] ts_data;
    logic       ts_start, ts_valid, ts_blk_err_n;

    always #10 clk = ~clk;

    ts_out_formatter i_ts_out_formatter (
        .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_err(src_err),
        .src_valid(src_valid), .src_ready(src_ready),
        .cfg_serial(cfg_serial), .cfg_lane_swap(cfg_lane_swap),
        .cfg_tei_force(cfg_tei_force), .cfg_edge_rise(cfg_edge_rise),
        .cfg_oe_n(cfg_oe_n), .ts_data(ts_data), .ts_start(ts_start),
        .ts_valid(ts_valid), .ts_blk_err_n(ts_blk_err_n)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [7:0]  sq[$];
    logic        sqerr[$];
    logic [10:0] exp_q[$];
    int          exp_code[$];
    logic        hs_next = 1'b0;
    logic        src_hold = 1'b0;
    int          cons_idx = 0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string rname(input int c);
        case (c)
            2:       return "R2";
            6:       return "R6";
            8:       return "R8";
            9:       return "R9";
            10:      return "R10";
            default: return "R1";
        endcase
    endfunction

    // expected slots of the packet whose first byte was just taken
    task automatic push_packet();
        logic bad;
        bad = sqerr[0];
        for (int j = 0; j < 188; j++) begin
            logic [7:0] v;
            int         code;
            v = sq[j];
            if (j == 1 && bad && cfg_tei_force) v[7] = 1'b1;
            code = (j == 1 && bad) ? 6 : (cfg_serial ? 9 : 1);
            if (!cfg_serial) begin
                exp_q.push_back({v, (j == 0), 1'b1, !bad});
                exp_code.push_back(code);
            end else begin
                for (int k = 0; k < 8; k++) begin
                    logic [7:0] d;
                    d = cfg_lane_swap ? {v[7-k], 7'b0} : {7'b0, v[7-k]};
                    exp_q.push_back({d, (j == 0), 1'b1, !bad});
                    exp_code.push_back(code);
                end
            end
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    // per-clock reference model and comparison
    initial begin
        logic [10:0] early, late, prev_late, e;
        int          code;
        prev_late = 11'h001;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (hs_next) begin
                if (cons_idx == 0) push_packet();
                void'(sq.pop_front());
                void'(sqerr.pop_front());
                cons_idx = (cons_idx == 187) ? 0 : cons_idx + 1;
            end
            #4;
            early = {ts_data, ts_start, ts_valid, ts_blk_err_n};
            #5;
            src_valid = !src_hold && (sq.size() > 0);
            src_data  = src_valid ? sq[0] : 8'h00;
            src_err   = src_valid ? sqerr[0] : 1'b0;
            #1;
            hs_next = src_valid && src_ready;
            #4;
            late = {ts_data, ts_start, ts_valid, ts_blk_err_n};
            if (exp_q.size() > 0) begin
                e    = exp_q.pop_front();
                code = exp_code.pop_front();
            end else begin
                e    = 11'h001;
                code = cfg_oe_n ? 8 : (src_hold ? 10 : 2);
            end
            chk(rname(code), late[10:3], e[10:3]);
            chk("R3", {7'b0, late[2]}, {7'b0, e[2]});
            chk("R4", {7'b0, late[1]}, {7'b0, e[1]});
            chk("R5", {7'b0, late[0]}, {7'b0, e[0]});
            // R7: launch edge seen at the quarter-period sample
            if (cfg_edge_rise) chk("R7", early[10:3] ^ {early[2:0], 5'b0}, late[10:3] ^ {late[2:0], 5'b0});
            else               chk("R7", early[10:3] ^ {early[2:0], 5'b0}, prev_late[10:3] ^ {prev_late[2:0], 5'b0});
            if (cfg_oe_n) chk("R8", {7'b0, src_ready}, 8'h00);
            prev_late = late;
        end
    end

    task automatic send_pkt(input logic bad, input logic [7:0] b1, input int seed);
        for (int j = 0; j < 188; j++) begin
            logic [7:0] b;
            b = (j == 0) ? 8'h47 : (j == 1) ? b1 : 8'((j * 13 + seed) & 255);
            sq.push_back(b);
            sqerr.push_back(bad);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drain();
        do @(posedge clk); while (sq.size() != 0 || exp_q.size() != 0);
        step(3);
    endtask

    initial begin
        #25;
        // R11: reset values
        chk("R11", ts_data, 8'h00);
        chk("R11", {5'b0, ts_start, ts_valid, ts_blk_err_n}, 8'h01);
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R11", {7'b0, src_ready}, 8'h01);
        chk("R11", {5'b0, ts_start, ts_valid, ts_blk_err_n}, 8'h01);

        // parallel, falling launch, forced indicator, back to back (R1 R6 R10)
        send_pkt(1'b0, 8'h12, 3);
        send_pkt(1'b1, 8'h12, 5);
        send_pkt(1'b0, 8'h34, 9);
        drain();

        // source withheld at a boundary (R10)
        src_hold = 1'b1;
        send_pkt(1'b1, 8'h20, 11);
        step(12);
        chk("R10", {7'b0, ts_valid}, 8'h00);
        src_hold = 1'b0;
        drain();

        // indicator pass-through (R6)
        cfg_tei_force = 1'b0;
        send_pkt(1'b1, 8'h15, 21);
        send_pkt(1'b1, 8'h95, 23);
        drain();
        cfg_tei_force = 1'b1;

        // rising launch (R7)
        cfg_edge_rise = 1'b1;
        step(2);
        send_pkt(1'b0, 8'h00, 31);
        send_pkt(1'b1, 8'h00, 33);
        drain();
        cfg_edge_rise = 1'b0;
        step(2);

        // output disabled (R8)
        cfg_oe_n = 1'b1;
        step(1);
        send_pkt(1'b1, 8'h44, 41);
        step(20);
        chk("R8", {7'b0, src_ready}, 8'h00);
        chk("R8", 8'(sq.size()), 8'd188);
        cfg_oe_n = 1'b0;
        drain();

        // serial on line 0, then line 7 (R9)
        cfg_serial = 1'b1;
        step(2);
        send_pkt(1'b1, 8'h01, 51);
        drain();
        cfg_lane_swap = 1'b1;
        step(2);
        send_pkt(1'b0, 8'h5a, 53);
        drain();
        cfg_serial = 1'b0;
        cfg_lane_swap = 1'b0;
        step(4);

        summary();
        $finish;
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog R1 actual=running expected=done");
        summary();
        $finish;
    end
endmodule